// File: doc/BRIEF.md
# Sequence Step Detector with Hold Timer

This block gates one step of a supply sequencing state machine. When the controller pulses `start_i`, the detector captures a configuration: which bit of the watched vector to follow, whether that bit is active low, whether to skip the wait entirely, and how many microseconds the chosen bit must stay at its target level. It then waits for that condition and raises `advance_o` for exactly one clock. After that it stays idle until the next start strobe.

The watched vector mixes supply-fault flags and logic inputs. The block treats all of them as plain level bits. The hold timer counts whole microseconds, and each microsecond is `CLKS_PER_US` clocks from an internal prescaler. If the watched bit leaves its target level at any point, both counters return to zero. A qualifying level therefore has to be held without a break; a single edge is not enough. With the force option set, the block advances at once and ignores the inputs.

All pins are plain level-sampled control signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `seq_step_detector`

## Requirements
- R1: While reset is asserted, and afterwards until the first `start_i`, `advance_o` stays low whatever the watched inputs do.
- R2: `sel_i`, `invert_i`, `force_i` and `hold_us_i` are captured on the clock edge where `start_i` is high. Changing them later has no effect on the pending step.
- R3: The watched bit is `watch_i[sel_i]`, where bit 0 is the least significant bit of `watch_i`.
- R4: With `invert_i`=0 the target level is 1. With `invert_i`=1 the target level is 0.
- R5: Once armed, the block counts the clock edges in an unbroken run of matching input. When that run reaches `hold_us_i*CLKS_PER_US` edges, `advance_o` goes high on the next edge. Counting from the capture edge, the pulse is seen `hold_us_i*CLKS_PER_US+1` edges later when the input already matches.
- R6: A single edge on which the watched bit is off target clears the hold timer. The full hold then has to be met again from the next matching edge.
- R7: With `hold_us_i`=0, `advance_o` goes high on the edge after the first armed edge on which the input matches.
- R8: With `force_i`=1, `advance_o` goes high on the first armed edge, whatever the value of `watch_i`.
- R9: `advance_o` is high for exactly one clock. After the pulse, no further pulse occurs until another `start_i`, even if the input still matches.
- R10: A `start_i` while a step is pending recaptures the configuration and restarts the hold from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Strobe that captures the configuration and arms the detector |
| sel_i | input | SEL_W | Index of the watched bit |
| invert_i | input | 1 | 1 = target level is low |
| force_i | input | 1 | 1 = advance without waiting on any input |
| hold_us_i | input | DLY_W | Required hold time in microseconds |
| watch_i | input | N_IN | Supply-fault and logic input vector |
| advance_o | output | 1 | One-clock pulse marking that the step is complete |

## Verification
On every cycle, the assertions check that the advance pulse lasts one clock and only follows an armed cycle. They also check that an off-target cycle never produces a pulse unless force is set, that the microsecond count only steps by one or drops to zero, and that the prescaler stays in range. Only the bench scenarios can show the exact latencies for each select, invert and hold setting. The same applies to the restart after a glitch, to ignoring configuration changes after capture, to the quiet period after a pulse, and to restarting on a new strobe.

// File: rtl/seq_step_pkg.sv
package seq_step_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } step_state_e;

  typedef struct packed {
    logic invert;
    logic force_adv;
  } step_flags_t;
endpackage

// File: rtl/seq_step_input_qual.sv
module seq_step_input_qual #(
  parameter int N_IN  = 8,
  parameter int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]  watch_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             invert_i,
  output logic             match_o
);
  logic [N_IN-1:0] picked;

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_pick
      assign picked[g] = watch_i[g] & (sel_i == SEL_W'(g));
    end
  endgenerate

  assign match_o = (|picked) ^ invert_i;
endmodule

// File: rtl/seq_step_hold_timer.sv
module seq_step_hold_timer #(
  parameter int CLKS_PER_US = 200,
  parameter int DLY_W       = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DLY_W-1:0] hold_us_i,
  output logic             reached_o
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0]    presc_q;
  logic [DLY_W-1:0] us_q;

  assign reached_o = (us_q >= hold_us_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      us_q    <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
      us_q    <= '0;
    end else if (run_i && !reached_o) begin
      if (presc_q == P_LAST) begin
        presc_q <= '0;
        us_q    <= us_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assert_presc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= P_LAST);

  assert_us_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (us_q != $past(us_q)) |-> (us_q == $past(us_q) + 1'b1 || us_q == '0));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (us_q == '0 && presc_q == '0));
endmodule

// File: rtl/seq_step_detector.sv
module seq_step_detector
  import seq_step_pkg::*;
#(
  parameter int N_IN        = 8,
  parameter int SEL_W       = (N_IN > 1) ? $clog2(N_IN) : 1,
  parameter int DLY_W       = 19,
  parameter int CLKS_PER_US = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             invert_i,
  input  logic             force_i,
  input  logic [DLY_W-1:0] hold_us_i,
  input  logic [N_IN-1:0]  watch_i,
  output logic             advance_o
);
  step_state_e      state_q;
  step_flags_t      flags_q;
  logic [SEL_W-1:0] sel_q;
  logic [DLY_W-1:0] hold_q;
  logic             adv_q;
  logic             match;
  logic             reached;
  logic             armed;
  logic             fire;

  assign armed = (state_q == ST_ARMED);

  seq_step_input_qual #(.N_IN(N_IN), .SEL_W(SEL_W)) u_qual (
    .watch_i  (watch_i),
    .sel_i    (sel_q),
    .invert_i (flags_q.invert),
    .match_o  (match)
  );

  seq_step_hold_timer #(.CLKS_PER_US(CLKS_PER_US), .DLY_W(DLY_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_i | (armed & ~match)),
    .run_i     (armed & match),
    .hold_us_i (hold_q),
    .reached_o (reached)
  );

  assign fire = armed & (flags_q.force_adv | (match & reached));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      sel_q   <= '0;
      hold_q  <= '0;
      adv_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ARMED;
      flags_q <= '{invert: invert_i, force_adv: force_i};
      sel_q   <= sel_i;
      hold_q  <= hold_us_i;
      adv_q   <= 1'b0;
    end else begin
      adv_q <= fire;
      if (fire) state_q <= ST_IDLE;
    end
  end

  assign advance_o = adv_q;

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |=> !advance_o);

  assert_pulse_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(advance_o) |-> $past(armed));

  assert_idle_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_o && !$past(start_i)) |-> !armed);

  assert_offtarget_no_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !match && !flags_q.force_adv && !start_i) |=> !advance_o);

  assert_force_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flags_q.force_adv && !start_i) |=> advance_o);
endmodule

// File: tb/seq_step_detector_tb_top.sv
`timescale 1ns/1ps
module seq_step_detector_tb_top;
  localparam int N_IN = 8;
  localparam int SEL_W = 3;
  localparam int DLY_W = 8;
  localparam int P = 4;
  localparam int NV = 8;

  // vector: {sel[20:18], inv[17], force[16], hold[15:8], watch[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 8'd0, 8'h01},
    {3'd3, 1'b0, 1'b0, 8'd2, 8'h08},
    {3'd7, 1'b0, 1'b0, 8'd1, 8'h80},
    {3'd5, 1'b1, 1'b0, 8'd3, 8'hDF},
    {3'd2, 1'b1, 1'b0, 8'd0, 8'h04},
    {3'd4, 1'b0, 1'b0, 8'd1, 8'hEF},
    {3'd1, 1'b0, 1'b1, 8'd9, 8'h00},
    {3'd6, 1'b1, 1'b1, 8'd0, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [SEL_W-1:0] sel_i = '0;
  logic invert_i = 1'b0;
  logic force_i = 1'b0;
  logic [DLY_W-1:0] hold_us_i = '0;
  logic [N_IN-1:0] watch_i = '0;
  logic advance_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_step_detector #(.N_IN(N_IN), .SEL_W(SEL_W), .DLY_W(DLY_W), .CLKS_PER_US(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
    .invert_i(invert_i), .force_i(force_i), .hold_us_i(hold_us_i),
    .watch_i(watch_i), .advance_o(advance_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm(input logic [2:0] s, input logic inv, input logic f, input logic [7:0] h);
    @(negedge clk);
    sel_i = s; invert_i = inv; force_i = f; hold_us_i = h; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_adv(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (advance_o) begin n = i; break; end
    end
  endtask

  initial begin
    int n;
    int exp;
    bit m;
    // R1: reset and idle before any start
    watch_i = '1;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(advance_o), 0);
    rst_n = 1'b1;
    wait_adv(20, n);
    check("R1 no start", n, 0);

    // R3 R4 R5 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      watch_i = VEC[v][7:0];
      arm(VEC[v][20:18], VEC[v][17], VEC[v][16], VEC[v][15:8]);
      m = VEC[v][7:0][VEC[v][20:18]] ^ VEC[v][17];
      if (VEC[v][16]) exp = 1;
      else if (m) exp = int'(VEC[v][15:8]) * P + 1;
      else exp = 0;
      wait_adv(int'(VEC[v][15:8]) * P + 20, n);
      check($sformatf("R3 R4 R5 R7 R8 vec%0d", v), n, exp);
      if (n != 0) begin
        @(negedge clk);
        check("R9 width", int'(advance_o), 0);
      end
      if (exp == 0) begin
        watch_i = ~watch_i;
        arm(3'd0, 1'b0, 1'b1, 8'd0);
        wait_adv(5, n);
      end
    end

    // R6: glitch restarts the hold
    watch_i = '0;
    arm(3'd0, 1'b0, 1'b0, 8'd3);
    watch_i = 8'h01;
    wait_adv(8, n);
    check("R6 early", n, 0);
    watch_i = 8'h00;
    @(negedge clk);
    watch_i = 8'h01;
    wait_adv(40, n);
    check("R6 restart", n, 3 * P + 1);

    // R2: later config changes ignored
    watch_i = 8'h04;
    arm(3'd2, 1'b0, 1'b0, 8'd1);
    sel_i = 3'd0; invert_i = 1'b1; force_i = 1'b1; hold_us_i = 8'd0;
    wait_adv(30, n);
    check("R2 latched", n, P + 1);

    // R9: no further pulse until new start
    wait_adv(40, n);
    check("R9 idle", n, 0);
    arm(3'd2, 1'b0, 1'b0, 8'd0);
    wait_adv(10, n);
    check("R9 rearm", n, 1);

    // R10: start while pending restarts
    watch_i = 8'h02;
    arm(3'd1, 1'b0, 1'b0, 8'd5);
    wait_adv(10, n);
    check("R10 pending", n, 0);
    arm(3'd1, 1'b0, 1'b0, 8'd5);
    wait_adv(60, n);
    check("R10 restart", n, 5 * P + 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=complete");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule